// File: doc/BRIEF.md
# Inbound Message Mailbox

This block is a small mailbox through which an internal agent hands 32-bit messages to a host processor. Messages arrive on a push port driven by a response collector. They wait in an eight-deep first-in-first-out store until the host takes them by reading a word-wide register interface.

The host has five readable windows. It can take the oldest message, look at it without removing it, read a status word with full and empty flags, and read a configuration word that holds an interrupt enable and a data-waiting flag. It can also read the full and empty state of a second mailbox, the outbound one, which is supplied on two input pins. The interrupt output rises while messages wait and the host has enabled it. Each read returns its data one cycle after the access. The store keeps its entries packed toward slot 0, and every unused slot holds the all-ones invalid marker.

Top module: `mbox_inbound`

## Requirements
- R1: A synchronous reset clears the count and the interrupt enable, fills every slot with 0xFFFFFFFF and drives the interrupt low. After reset, the status word reads 0x40000000 and the config word reads 0.
- R2: A full-word read at any offset from 0x80 to 0x8C removes the oldest entry and returns it on acc_rdata in the cycle after the access. Entries leave in the order they were pushed.
- R3: A removing read while the store is empty returns 0xFFFFFFFF and leaves the count unchanged.
- R4: A read at offset 0x90 returns slot 0 without removing it. When the store is empty, slot 0 holds 0xFFFFFFFF.
- R5: The status word at 0x98 has bit 31 set exactly when 8 entries are held and bit 30 set exactly when none are held. All other bits read 0.
- R6: The config word at 0x9C returns the interrupt enable in bit 0 and the data-waiting flag in bit 4; the flag is 1 whenever the store is non-empty. A write to this offset changes only the enable, which takes the value of write-data bit 0.
- R7: irq is high exactly when both the enable and the data-waiting flag are set. It changes at the same clock edge as the state it follows.
- R8: A read at 0xB8 returns {ob_full, ob_empty, 30'b0}. A read at any unlisted offset returns 0. A write to any offset other than 0x9C has no effect.
- R9: Only address bits 7:0 are decoded, so addresses that differ only above bit 7 reach the same register.
- R10: An access whose byte enables are not all four set is ignored. It does not remove an entry or write the config word, and acc_rdata reads 0 in the next cycle.
- R11: A push while 8 entries are held is dropped, and the stored contents stay unchanged.
- R12: A push and a removing read in the same cycle both take effect: the old head is returned and the new entry joins the tail. After a removal, the freed tail slot holds 0xFFFFFFFF again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Register access in this cycle |
| acc_wr | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | ADDR_W (12) | Byte address; bits 7:2 are decoded |
| acc_be | input | 4 | Byte enables; only 4'b1111 is accepted |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data, valid the cycle after a read (0 otherwise) |
| push_valid | input | 1 | Push a message this cycle |
| push_data | input | 32 | Message to push |
| ob_full | input | 1 | Outbound mailbox full flag |
| ob_empty | input | 1 | Outbound mailbox empty flag |
| irq | output | 1 | Data-available interrupt, registered |

## Verification
The assertions assume that acc_addr is at least 9 bits wide and that ob_full and ob_empty are never both high. They also assume that a removing read and a push may coincide only when the store holds fewer than 8 entries. The stimulus respects these limits. The outbound flags are only ever set to one of the two legal combinations, and the single simultaneous push-and-remove is issued with one entry held. The full case is reached by plain pushes alone, with no reads issued during them.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned MB_DATA_W = 32;
  localparam logic [MB_DATA_W-1:0] MB_MARK = '1;
  // Word offsets (byte offset bits 7:2)
  localparam logic [5:0] WOFF_POP_BASE = 6'h20; // 0x80..0x8C, low two word bits free
  localparam logic [5:0] WOFF_PEEK     = 6'h24; // 0x90
  localparam logic [5:0] WOFF_STATUS   = 6'h26; // 0x98
  localparam logic [5:0] WOFF_CONFIG   = 6'h27; // 0x9C
  localparam logic [5:0] WOFF_OB_STAT  = 6'h2E; // 0xB8
  localparam int unsigned CFG_EN_BIT   = 0;
  localparam int unsigned CFG_PEND_BIT = 4;
endpackage

// File: rtl/mbox_shift_fifo.sv
module mbox_shift_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 32,
  parameter logic [W-1:0] MARK = '1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic [W-1:0]  push_data,
  input  logic          pop_req,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          nonempty_nxt
);
  logic [W-1:0]  slot_q   [DEPTH];
  logic [W-1:0]  slot_nxt [DEPTH];
  logic [CW-1:0] count_q, count_nxt, wr_idx;
  logic          do_push, do_pop;

  assign full    = (count_q == CW'(DEPTH));
  assign empty   = (count_q == '0);
  assign do_pop  = pop_req && !empty;
  assign do_push = push_req && !full;
  assign wr_idx  = do_pop ? CW'(count_q - CW'(1)) : count_q;

  always_comb begin
    count_nxt = count_q;
    if (do_push && !do_pop) count_nxt = CW'(count_q + CW'(1));
    if (do_pop && !do_push) count_nxt = CW'(count_q - CW'(1));
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] upper;
    if (i == DEPTH - 1) begin : g_last
      assign upper = MARK;
    end else begin : g_mid
      assign upper = (CW'(i + 1) < count_q) ? slot_q[i+1] : MARK;
    end
    always_comb begin
      slot_nxt[i] = slot_q[i];
      if (do_pop) slot_nxt[i] = upper;
      if (do_push && wr_idx == CW'(i)) slot_nxt[i] = push_data;
    end
    always_ff @(posedge clk) begin
      if (rst) slot_q[i] <= MARK;
      else     slot_q[i] <= slot_nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_nxt;
  end

  assign head         = slot_q[0];
  assign count        = count_q;
  assign nonempty_nxt = (count_nxt != '0);

  assert_count_bound_R11: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));
  assert_full_drop_R11: assert property (@(posedge clk) disable iff (rst)
    (full && push_req && !pop_req) |=> (count_q == CW'(DEPTH)) && $stable(slot_q[DEPTH-1]));
  assert_empty_pop_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (empty && pop_req && !push_req) |=> (count_q == '0));
  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
  assert_tail_marker_R12: assert property (@(posedge clk) disable iff (rst)
    !full |-> (slot_q[DEPTH-1] == MARK));
  assert_empty_head_R4: assert property (@(posedge clk) disable iff (rst)
    empty |-> (slot_q[0] == MARK));
endmodule

// File: rtl/mbox_irq_ctl.sv
module mbox_irq_ctl (
  input  logic clk,
  input  logic rst,
  input  logic cfg_we,
  input  logic cfg_en_bit,
  input  logic nonempty_nxt,
  output logic en,
  output logic irq
);
  logic en_q, en_nxt, irq_q;

  assign en_nxt = cfg_we ? cfg_en_bit : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= en_nxt;
      irq_q <= en_nxt && nonempty_nxt;
    end
  end

  assign en  = en_q;
  assign irq = irq_q;

  assert_irq_needs_en_R7: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> en_q);
  assert_en_from_write_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (en_q == $past(cfg_en_bit)));
  assert_en_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(en_q));
endmodule

// File: rtl/mbox_inbound.sv
module mbox_inbound
  import mbox_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc_en,
  input  logic                 acc_wr,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic [3:0]           acc_be,
  input  logic [MB_DATA_W-1:0] acc_wdata,
  output logic [MB_DATA_W-1:0] acc_rdata,
  input  logic                 push_valid,
  input  logic [MB_DATA_W-1:0] push_data,
  input  logic                 ob_full,
  input  logic                 ob_empty,
  output logic                 irq
);
  logic [7:0]           off;
  logic [5:0]           woff;
  logic                 whole, rd_ok, wr_ok, hit_pop, hit_cfg;
  logic [MB_DATA_W-1:0] head, rd_d, rd_q;
  logic [CW-1:0]        count;
  logic                 full, empty, nonempty_nxt, irq_en;
  logic                 unused_bits;

  assign off     = acc_addr[7:0];
  assign woff    = off[7:2];
  assign whole   = acc_en && (acc_be == 4'b1111);
  assign rd_ok   = whole && !acc_wr;
  assign wr_ok   = whole && acc_wr;
  assign hit_pop = (woff[5:2] == WOFF_POP_BASE[5:2]);
  assign hit_cfg = (woff == WOFF_CONFIG);
  assign unused_bits = ^{acc_addr[ADDR_W-1:8], off[1:0], acc_wdata[MB_DATA_W-1:1]};

  mbox_shift_fifo #(.DEPTH(DEPTH), .W(MB_DATA_W), .MARK(MB_MARK)) u_fifo (
    .clk          (clk),
    .rst          (rst),
    .push_req     (push_valid),
    .push_data    (push_data),
    .pop_req      (rd_ok && hit_pop),
    .head         (head),
    .count        (count),
    .full         (full),
    .empty        (empty),
    .nonempty_nxt (nonempty_nxt)
  );

  mbox_irq_ctl u_irq (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (wr_ok && hit_cfg),
    .cfg_en_bit   (acc_wdata[0]),
    .nonempty_nxt (nonempty_nxt),
    .en           (irq_en),
    .irq          (irq)
  );

  always_comb begin
    rd_d = '0;
    if (rd_ok) begin
      if (hit_pop) begin
        rd_d = empty ? MB_MARK : head;
      end else begin
        case (woff)
          WOFF_PEEK:    rd_d = head;
          WOFF_STATUS:  rd_d = {full, empty, 30'b0};
          WOFF_CONFIG: begin
            rd_d[CFG_EN_BIT]   = irq_en;
            rd_d[CFG_PEND_BIT] = !empty;
          end
          WOFF_OB_STAT: rd_d = {ob_full, ob_empty, 30'b0};
          default:      rd_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_d;
  end

  assign acc_rdata = rd_q;

  assert_empty_read_marker_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && hit_pop && empty) |=> (acc_rdata == MB_MARK));
  assert_partial_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_be != 4'b1111) |=> (acc_rdata == '0));
  assert_pop_count_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && hit_pop && !empty && !push_valid) |=> (count == $past(count) - CW'(1)));
  assert_count_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!push_valid && !(rd_ok && hit_pop)) |=> $stable(count));
  assert_irq_pending_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> !empty);
endmodule

// File: tb/sim_mbox_inbound.sv
module sim_mbox_inbound;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_en = 1'b0, acc_wr = 1'b0;
  logic [11:0] acc_addr = '0;
  logic [3:0]  acc_be = 4'hF;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        push_valid = 1'b0;
  logic [31:0] push_data = '0;
  logic        ob_full = 1'b0, ob_empty = 1'b1;
  logic        irq;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  mbox_inbound u0 (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_be(acc_be), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .push_valid(push_valid), .push_data(push_data), .ob_full(ob_full),
    .ob_empty(ob_empty), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  op;   // 0 push, 1 read+check, 2 write
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 12'h098, 32'h0,        32'h4000_0000, 8'd5},  // R5 empty flag
    '{2'd1, 12'h09C, 32'h0,        32'h0,         8'd1},  // R1 config clear
    '{2'd1, 12'h080, 32'h0,        32'hFFFF_FFFF, 8'd3},  // R3 empty pop
    '{2'd1, 12'h090, 32'h0,        32'hFFFF_FFFF, 8'd4},  // R4 empty peek
    '{2'd0, 12'h000, 32'h11,       32'h0,         8'd2},
    '{2'd0, 12'h000, 32'h22,       32'h0,         8'd2},
    '{2'd1, 12'h090, 32'h0,        32'h11,        8'd4},  // R4 peek head
    '{2'd1, 12'h09C, 32'h0,        32'h10,        8'd6},  // R6 pending
    '{2'd2, 12'h09C, 32'hFFFF_FFFF, 32'h0,        8'd6},
    '{2'd1, 12'h09C, 32'h0,        32'h11,        8'd6},  // R6 only bit 0 set
    '{2'd1, 12'h084, 32'h0,        32'h11,        8'd2},  // R2 pop oldest
    '{2'd1, 12'h18C, 32'h0,        32'h22,        8'd9},  // R9 alias above bit 7
    '{2'd1, 12'h098, 32'h0,        32'h4000_0000, 8'd5},
    '{2'd1, 12'h09C, 32'h0,        32'h01,        8'd6},
    '{2'd1, 12'h0B8, 32'h0,        32'h4000_0000, 8'd8},  // R8 outbound
    '{2'd1, 12'h0A0, 32'h0,        32'h0,         8'd8},  // R8 unlisted
    '{2'd2, 12'h098, 32'h0,        32'h0,         8'd8},  // R8 write ignored
    '{2'd1, 12'h090, 32'h0,        32'hFFFF_FFFF, 8'd12}  // R12 freed slot
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_push(input logic [31:0] d);
    @(negedge clk); push_valid = 1'b1; push_data = d;
    @(negedge clk); push_valid = 1'b0;
  endtask

  task automatic do_acc(input logic wr, input logic [11:0] a, input logic [3:0] be,
                        input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk); acc_en = 1'b1; acc_wr = wr; acc_addr = a; acc_be = be; acc_wdata = d;
    @(negedge clk); acc_en = 1'b0; acc_wr = 1'b0; acc_be = 4'hF;
    rd = acc_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    do_reset();
    check("R1 irq after reset", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (TBL[i].op)
        2'd0: do_push(TBL[i].data);
        2'd2: do_acc(1'b1, TBL[i].addr, 4'hF, TBL[i].data, r);
        default: begin
          do_acc(1'b0, TBL[i].addr, 4'hF, 32'h0, r);
          check($sformatf("R%0d table row %0d", TBL[i].req, i), r, TBL[i].exp);
        end
      endcase
    end

    // R7: interrupt follows enable and pending
    check("R7 enabled but empty", {31'b0, irq}, 32'h0);
    do_push(32'hA5);
    check("R7 irq after push", {31'b0, irq}, 32'h1);
    do_acc(1'b1, 12'h09C, 4'hF, 32'h0, r);
    check("R7 irq after disable", {31'b0, irq}, 32'h0);
    do_acc(1'b1, 12'h09C, 4'hF, 32'h1, r);
    check("R7 irq after re-enable", {31'b0, irq}, 32'h1);
    do_acc(1'b0, 12'h080, 4'hF, 32'h0, r);
    check("R2 pop A5", r, 32'hA5);
    check("R7 irq after drain", {31'b0, irq}, 32'h0);

    // R10: partial accesses ignored
    do_push(32'h77);
    do_acc(1'b0, 12'h080, 4'b0111, 32'h0, r);
    check("R10 partial read data", r, 32'h0);
    do_acc(1'b0, 12'h090, 4'hF, 32'h0, r);
    check("R10 entry kept", r, 32'h77);
    do_acc(1'b1, 12'h09C, 4'b0011, 32'h0, r);
    do_acc(1'b0, 12'h09C, 4'hF, 32'h0, r);
    check("R10 config kept", r, 32'h11);

    // R12: simultaneous push and pop with one entry held
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = 12'h088; acc_be = 4'hF;
    push_valid = 1'b1; push_data = 32'hBEEF;
    @(negedge clk);
    acc_en = 1'b0; push_valid = 1'b0;
    check("R12 pop returns old head", acc_rdata, 32'h77);
    do_acc(1'b0, 12'h090, 4'hF, 32'h0, r);
    check("R12 new entry at head", r, 32'hBEEF);
    do_acc(1'b0, 12'h08C, 4'hF, 32'h0, r);
    check("R12 drain", r, 32'hBEEF);

    // R11 / R5: fill beyond capacity, then drain in order
    for (int k = 1; k <= 9; k++) do_push(32'h100 + k);
    do_acc(1'b0, 12'h098, 4'hF, 32'h0, r);
    check("R5 full flag", r, 32'h8000_0000);
    for (int k = 1; k <= 8; k++) begin
      do_acc(1'b0, 12'h080, 4'hF, 32'h0, r);
      check($sformatf("R2 order slot %0d", k), r, 32'h100 + k);
    end
    do_acc(1'b0, 12'h080, 4'hF, 32'h0, r);
    check("R11 ninth push dropped", r, 32'hFFFF_FFFF);
    do_acc(1'b0, 12'h098, 4'hF, 32'h0, r);
    check("R3 count unchanged after empty pop", r, 32'h4000_0000);

    // R8: outbound full
    ob_full = 1'b1; ob_empty = 1'b0;
    do_acc(1'b0, 12'h0B8, 4'hF, 32'h0, r);
    check("R8 outbound full", r, 32'h8000_0000);

    // R1: reset mid-operation
    do_push(32'h55);
    do_reset();
    check("R1 irq cleared", {31'b0, irq}, 32'h0);
    do_acc(1'b0, 12'h098, 4'hF, 32'h0, r);
    check("R1 status after reset", r, 32'h4000_0000);
    do_acc(1'b0, 12'h09C, 4'hF, 32'h0, r);
    check("R1 config after reset", r, 32'h0);
    do_acc(1'b0, 12'h090, 4'hF, 32'h0, r);
    check("R1 head marker after reset", r, 32'hFFFF_FFFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule